// File: doc/BRIEF.md
# Micro-Operation Sequenced Accumulator Core

This block is a small accumulator processor whose control is a hardwired sequencer. It does exactly one group of register transfers per clock. Every instruction goes through a fetch cycle, then an optional indirect-address cycle, then an execute cycle. An interrupt cycle may follow the execute cycle. The core holds a program counter, a memory address register, a memory buffer register, an instruction register (opcode and address field) and one accumulator.

It drives a single-ported synchronous word memory with one clock of read latency. There are three instructions, each with an indirect flag:
- add a memory word to the accumulator;
- increment a memory word, and skip the next instruction when the result is zero;
- branch to a target after storing the return address there.

The interrupt cycle has a few fixed steps:
- It stores the program counter at a fixed save address.
- It jumps to a fixed service address.
- It disarms interrupts until the arm input is pulsed again.

A debug output reports the current cycle kind and its step. With it, the exact micro-operation timing can be followed from outside.

Top module: `mopseq_core`

## Requirements
- R1: While `rst` is high, at every clock the core returns to fetch step 0. Debug reads cycle 0 step 0, PC and accumulator read 0, the interrupt enable is cleared, and both memory strobes are low.
- R2: Fetch takes three clocks.
  - Step 0 raises `mem_rd` with `mem_addr` equal to PC.
  - Step 1 loads the returned word and increments PC.
  - Step 2 loads the instruction register.
  - The next cycle is indirect when word bit 12 is set, and execute otherwise.
- R3: `mem_rd` and `mem_wr` are never high in the same clock. A word read with `mem_rd` high in one clock is captured on the following edge.
- R4: Instruction word encoding:
  - bits 15:13 are the opcode: 000 add, 001 increment-skip, 010 branch-and-save, and every other value is a no-op;
  - bit 12 is the indirect flag;
  - bits 11:0 are the operand address.
- R5: The indirect cycle takes three clocks. It reads the word at the address field and replaces the address field with bits 11:0 of that word. Execution then uses that address.
- R6: Add takes three execute clocks. Step 0 reads the operand. The accumulator becomes accumulator plus word, modulo 2^16, at the end of step 2. The accumulator changes in no other clock.
- R7: Increment-skip takes four execute clocks. It reads the operand at step 0. At step 3 it writes operand+1 (modulo 2^16) back to the same address. When that value is zero, PC is incremented once more at the end of step 3.
- R8: Branch-and-save takes three execute clocks. Step 1 writes the current PC (the return address) to the operand address. After step 2, PC equals operand address + 1.
- R9: A no-op opcode takes one execute clock, with no memory strobe and no change to PC or accumulator.
- R10: `irq` is acted on only in the last execute clock, and only while the interrupt enable is set. `int_arm` high at a clock edge sets the enable. Entering the interrupt cycle clears it, and this takes priority over `int_arm`.
- R11: The interrupt cycle takes three clocks. After step 1 PC equals `ISR_ADDR`. Step 2 writes the old PC to `SAVE_ADDR`. Fetch follows.
- R12: `dbg_cycle` encodes 0 fetch, 1 indirect, 2 execute, 3 interrupt. `dbg_step` counts from 0 within each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| irq | input | 1 | interrupt request |
| int_arm | input | 1 | sets the interrupt enable |
| mem_rdata | input | DW | read word, valid one clock after `mem_rd` |
| mem_addr | output | AW | memory address |
| mem_rd | output | 1 | read strobe |
| mem_wr | output | 1 | write strobe, write happens on this edge |
| mem_wdata | output | DW | write word |
| pc_out | output | AW | program counter |
| acc_out | output | DW | accumulator |
| dbg_cycle | output | 2 | current cycle kind |
| dbg_step | output | 2 | step within the cycle |

## Verification
A corrupted program counter appears on `mem_addr` at the very next fetch step 0, and on `pc_out` at once. A wrong sequencer state shows as a `dbg_cycle`/`dbg_step` mismatch in the same clock. A wrong buffer value reaches the ports later, as a wrong write word in a store step or a wrong accumulator one clock after an add. The reference model predicts every clock's strobes, address, write word, PC, accumulator and debug pair. A divergence is therefore reported in the clock where it first becomes visible.

// File: rtl/mopseq_pkg.sv
package mopseq_pkg;

  localparam int OPC_W  = 3;
  localparam int STEP_W = 2;

  localparam logic [OPC_W-1:0] OPC_ADD = 3'b000;
  localparam logic [OPC_W-1:0] OPC_ISZ = 3'b001;
  localparam logic [OPC_W-1:0] OPC_BSA = 3'b010;

  typedef enum logic [1:0] {
    CY_FETCH = 2'd0,
    CY_IND   = 2'd1,
    CY_EXEC  = 2'd2,
    CY_INT   = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {MAR_HOLD, MAR_PC, MAR_IR, MAR_SAVE} mar_sel_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_PC, MBR_INC} mbr_sel_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IR, PC_ISR, PC_SKIPZ} pc_sel_e;

  typedef struct packed {
    mar_sel_e mar;
    mbr_sel_e mbr;
    pc_sel_e  pc;
    logic     ir_all;
    logic     ir_addr;
    logic     acc_add;
    logic     rd;
    logic     wr;
  } uop_t;

endpackage

// File: rtl/mopseq_seq.sv
module mopseq_seq
  import mopseq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OPC_W-1:0]        opc,
  input  logic                    ind_flag,
  input  logic                    irq,
  input  logic                    int_arm,
  output uop_t                    uop,
  output cyc_e                    cyc_q,
  output logic [STEP_W-1:0]       step_q
);

  localparam logic [STEP_W-1:0] STEP_ONE = 1;

  cyc_e              nxt_cyc;
  logic [STEP_W-1:0] nxt_step;
  logic              exec_done;
  logic              go_int;
  logic              ie_q;

  always_comb begin
    uop       = '0;
    nxt_cyc   = cyc_q;
    nxt_step  = step_q + STEP_ONE;
    exec_done = 1'b0;
    go_int    = 1'b0;
    unique case (cyc_q)
      CY_FETCH: begin
        case (step_q)
          2'd0: begin uop.mar = MAR_PC; uop.rd = 1'b1; end
          2'd1: begin uop.mbr = MBR_MEM; uop.pc = PC_INC; end
          default: begin
            uop.ir_all = 1'b1;
            nxt_step   = '0;
            nxt_cyc    = ind_flag ? CY_IND : CY_EXEC;
          end
        endcase
      end
      CY_IND: begin
        case (step_q)
          2'd0: begin uop.mar = MAR_IR; uop.rd = 1'b1; end
          2'd1: uop.mbr = MBR_MEM;
          default: begin
            uop.ir_addr = 1'b1;
            nxt_step    = '0;
            nxt_cyc     = CY_EXEC;
          end
        endcase
      end
      CY_EXEC: begin
        case (opc)
          OPC_ADD: begin
            case (step_q)
              2'd0: begin uop.mar = MAR_IR; uop.rd = 1'b1; end
              2'd1: uop.mbr = MBR_MEM;
              default: begin uop.acc_add = 1'b1; exec_done = 1'b1; end
            endcase
          end
          OPC_ISZ: begin
            case (step_q)
              2'd0: begin uop.mar = MAR_IR; uop.rd = 1'b1; end
              2'd1: uop.mbr = MBR_MEM;
              2'd2: uop.mbr = MBR_INC;
              default: begin uop.wr = 1'b1; uop.pc = PC_SKIPZ; exec_done = 1'b1; end
            endcase
          end
          OPC_BSA: begin
            case (step_q)
              2'd0: begin uop.mar = MAR_IR; uop.mbr = MBR_PC; end
              2'd1: begin uop.pc = PC_IR; uop.wr = 1'b1; end
              default: begin uop.pc = PC_INC; exec_done = 1'b1; end
            endcase
          end
          default: exec_done = 1'b1;
        endcase
      end
      CY_INT: begin
        case (step_q)
          2'd0: uop.mbr = MBR_PC;
          2'd1: begin uop.mar = MAR_SAVE; uop.pc = PC_ISR; end
          default: begin
            uop.wr   = 1'b1;
            nxt_step = '0;
            nxt_cyc  = CY_FETCH;
          end
        endcase
      end
      default: ;
    endcase
    if (exec_done) begin
      nxt_step = '0;
      if (irq && ie_q) begin
        nxt_cyc = CY_INT;
        go_int  = 1'b1;
      end else begin
        nxt_cyc = CY_FETCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= CY_FETCH;
      step_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      cyc_q  <= nxt_cyc;
      step_q <= nxt_step;
      if (go_int)       ie_q <= 1'b0;
      else if (int_arm) ie_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mopseq_dp.sv
module mopseq_dp
  import mopseq_pkg::*;
#(
  parameter int             AW        = 12,
  parameter int             DW        = 16,
  parameter logic [AW-1:0]  SAVE_ADDR = 'hF00,
  parameter logic [AW-1:0]  ISR_ADDR  = 'hF01
) (
  input  logic              clk,
  input  logic              rst,
  input  uop_t              uop,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [AW-1:0]     pc_q,
  output logic [DW-1:0]     acc_q,
  output logic [OPC_W-1:0]  opc_q,
  output logic              ind_flag
);

  localparam int            IND_BIT = DW - OPC_W - 1;
  localparam logic [AW-1:0] PC_ONE  = 1;
  localparam logic [DW-1:0] DW_ONE  = 1;

  logic [AW-1:0] mar_q;
  logic [AW-1:0] mar_nxt;
  logic [DW-1:0] mbr_q;
  logic [AW-1:0] ira_q;

  always_comb begin
    unique case (uop.mar)
      MAR_PC:   mar_nxt = pc_q;
      MAR_IR:   mar_nxt = ira_q;
      MAR_SAVE: mar_nxt = SAVE_ADDR;
      default:  mar_nxt = mar_q;
    endcase
  end

  assign mem_addr  = (uop.mar != MAR_HOLD) ? mar_nxt : mar_q;
  assign mem_wdata = mbr_q;
  assign ind_flag  = mbr_q[IND_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      mbr_q <= '0;
      pc_q  <= '0;
      acc_q <= '0;
      opc_q <= '0;
      ira_q <= '0;
    end else begin
      if (uop.mar != MAR_HOLD) mar_q <= mar_nxt;
      case (uop.mbr)
        MBR_MEM: mbr_q <= mem_rdata;
        MBR_PC:  mbr_q <= {{(DW-AW){1'b0}}, pc_q};
        MBR_INC: mbr_q <= mbr_q + DW_ONE;
        default: ;
      endcase
      case (uop.pc)
        PC_INC:   pc_q <= pc_q + PC_ONE;
        PC_IR:    pc_q <= ira_q;
        PC_ISR:   pc_q <= ISR_ADDR;
        PC_SKIPZ: if (mbr_q == '0) pc_q <= pc_q + PC_ONE;
        default:  ;
      endcase
      if (uop.ir_all) begin
        opc_q <= mbr_q[DW-1 -: OPC_W];
        ira_q <= mbr_q[AW-1:0];
      end else if (uop.ir_addr) begin
        ira_q <= mbr_q[AW-1:0];
      end
      if (uop.acc_add) acc_q <= acc_q + mbr_q;
    end
  end

endmodule

// File: rtl/mopseq_core.sv
module mopseq_core
  import mopseq_pkg::*;
#(
  parameter int             AW        = 12,
  parameter int             DW        = 16,
  parameter logic [AW-1:0]  SAVE_ADDR = 'hF00,
  parameter logic [AW-1:0]  ISR_ADDR  = 'hF01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              int_arm,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata,
  output logic [AW-1:0]     pc_out,
  output logic [DW-1:0]     acc_out,
  output logic [1:0]        dbg_cycle,
  output logic [STEP_W-1:0] dbg_step
);

  uop_t              uop;
  cyc_e              cyc_q;
  logic [STEP_W-1:0] step_q;
  logic [OPC_W-1:0]  opc_q;
  logic              ind_flag;

  mopseq_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .opc      (opc_q),
    .ind_flag (ind_flag),
    .irq      (irq),
    .int_arm  (int_arm),
    .uop      (uop),
    .cyc_q    (cyc_q),
    .step_q   (step_q)
  );

  mopseq_dp #(
    .AW        (AW),
    .DW        (DW),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_q      (pc_out),
    .acc_q     (acc_out),
    .opc_q     (opc_q),
    .ind_flag  (ind_flag)
  );

  assign mem_rd    = uop.rd & ~rst;
  assign mem_wr    = uop.wr & ~rst;
  assign dbg_cycle = cyc_q;
  assign dbg_step  = step_q;

endmodule

// File: rtl/mopseq_chk.sv
module mopseq_chk
  import mopseq_pkg::*;
#(
  parameter int             AW        = 12,
  parameter int             DW        = 16,
  parameter logic [AW-1:0]  SAVE_ADDR = 'hF00,
  parameter logic [AW-1:0]  ISR_ADDR  = 'hF01
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [AW-1:0]     pc_out,
  input logic [DW-1:0]     acc_out,
  input logic [1:0]        dbg_cycle,
  input logic [STEP_W-1:0] dbg_step
);

  localparam logic [AW-1:0] PC_ONE = 1;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R3

  AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_FETCH && dbg_step == 2'd1) |=> (pc_out == $past(pc_out) + PC_ONE)); // R2

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_FETCH && dbg_step == 2'd2) |=>
      ((dbg_cycle == CY_IND || dbg_cycle == CY_EXEC) && dbg_step == 2'd0)); // R2

  AST_IND_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_IND && dbg_step == 2'd2) |=> (dbg_cycle == CY_EXEC && dbg_step == 2'd0)); // R5

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle != CY_EXEC) |=> $stable(acc_out)); // R6

  AST_INT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_INT && dbg_step == 2'd0) |-> ($past(dbg_cycle) == CY_EXEC && $past(irq))); // R10

  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_INT && dbg_step == 2'd1) |=> (pc_out == ISR_ADDR)); // R11

  AST_INT_SAVE: assert property (@(posedge clk) disable iff (rst)
    (dbg_cycle == CY_INT && dbg_step == 2'd2) |-> (mem_wr && mem_addr == SAVE_ADDR)); // R11

endmodule

bind mopseq_core mopseq_chk #(
  .AW        (AW),
  .DW        (DW),
  .SAVE_ADDR (SAVE_ADDR),
  .ISR_ADDR  (ISR_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .pc_out    (pc_out),
  .acc_out   (acc_out),
  .dbg_cycle (dbg_cycle),
  .dbg_step  (dbg_step)
);

// File: tb/mopseq_core_bench.sv
`timescale 1ns/1ps
module mopseq_core_bench;

  localparam int AW    = 12;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int SAVE  = 'hF00;
  localparam int ISR   = 'hF01;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic          int_arm = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] pc_out;
  logic [DW-1:0] acc_out;
  logic [1:0]    dbg_cycle;
  logic [1:0]    dbg_step;

  mopseq_core #(.AW(AW), .DW(DW), .SAVE_ADDR(12'hF00), .ISR_ADDR(12'hF01)) u_mopseq_core (
    .clk(clk), .rst(rst), .irq(irq), .int_arm(int_arm), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .pc_out(pc_out), .acc_out(acc_out), .dbg_cycle(dbg_cycle), .dbg_step(dbg_step)
  );

  // bench memory: one-clock read latency, write on strobed edge
  logic [DW-1:0] mem [DEPTH];
  logic          load_en = 1'b0;
  logic [AW-1:0] load_a = '0;
  logic [DW-1:0] load_d = '0;

  always @(posedge clk) begin
    if (load_en) mem[load_a] <= load_d;
    else begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  // program image; encoding per R4: [15:13] opcode, [12] indirect, [11:0] address
  function automatic logic [15:0] prog(input int a);
    case (a)
      'h000: return 16'h0040;  // add 0x40
      'h001: return 16'h1041;  // add indirect via 0x41
      'h002: return 16'h2043;  // isz 0x43 -> 0xFFFF
      'h003: return 16'h2043;  // isz 0x43 -> 0, skip
      'h004: return 16'h0040;  // skipped
      'h005: return 16'h4050;  // bsa 0x50
      'h040: return 16'h1234;
      'h041: return 16'h0042;
      'h042: return 16'hFFFF;
      'h043: return 16'hFFFE;
      'h044: return 16'h0077;
      'h045: return 16'h0060;
      'h051: return 16'h6000;  // no-op opcode 011
      'h052: return 16'hF044;  // opcode 111, indirect
      'h053: return 16'h5045;  // bsa indirect via 0x45
      'h061: return 16'h0040;
      'hF01: return 16'h2043;  // service routine: isz 0x43
      default: return 16'h0000;
    endcase
  endfunction

  typedef struct {
    int cyc; int step; bit rd; bit wr; int addr; int wdata;
    int pc; int acc; bit last; string req;
  } rec_t;

  rec_t q[$];
  logic [15:0] ref_mem [DEPTH];
  int mpc = 0, macc = 0, mie = 0;
  int n_int_exp = 0, n_int_seen = 0, last_saved = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (time %0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic void push(int c, int s, bit rd, bit wr, int a, int wd, bit last, string req);
    rec_t r;
    r.cyc = c; r.step = s; r.rd = rd; r.wr = wr; r.addr = a; r.wdata = wd;
    r.pc = mpc; r.acc = macc; r.last = last; r.req = req;
    q.push_back(r);
  endfunction

  function automatic void gen_instr();
    int w, opc, a, v;
    push(0, 0, 1, 0, mpc, 0, 0, "R2");
    push(0, 1, 0, 0, 0, 0, 0, "R2");
    w = ref_mem[mpc];
    mpc = (mpc + 1) & 'hFFF;
    push(0, 2, 0, 0, 0, 0, 0, "R2");
    opc = (w >> 13) & 7;
    a = w & 'hFFF;
    if (((w >> 12) & 1) == 1) begin
      push(1, 0, 1, 0, a, 0, 0, "R5");
      push(1, 1, 0, 0, 0, 0, 0, "R5");
      push(1, 2, 0, 0, 0, 0, 0, "R5");
      a = ref_mem[a] & 'hFFF;
    end
    case (opc)
      0: begin
        push(2, 0, 1, 0, a, 0, 0, "R6");
        push(2, 1, 0, 0, 0, 0, 0, "R6");
        push(2, 2, 0, 0, 0, 0, 1, "R6");
        macc = (macc + ref_mem[a]) & 'hFFFF;
      end
      1: begin
        v = (ref_mem[a] + 1) & 'hFFFF;
        push(2, 0, 1, 0, a, 0, 0, "R7");
        push(2, 1, 0, 0, 0, 0, 0, "R7");
        push(2, 2, 0, 0, 0, 0, 0, "R7");
        push(2, 3, 0, 1, a, v, 1, "R7");
        ref_mem[a] = 16'(v);
        if (v == 0) mpc = (mpc + 1) & 'hFFF;
      end
      2: begin
        push(2, 0, 0, 0, 0, 0, 0, "R8");
        push(2, 1, 0, 1, a, mpc, 0, "R8");
        ref_mem[a] = 16'(mpc);
        mpc = a;
        push(2, 2, 0, 0, 0, 0, 1, "R8");
        mpc = (a + 1) & 'hFFF;
      end
      default: push(2, 0, 0, 0, 0, 0, 1, "R9");
    endcase
  endfunction

  function automatic void gen_int();
    push(3, 0, 0, 0, 0, 0, 0, "R11");
    push(3, 1, 0, 0, 0, 0, 0, "R11");
    last_saved = mpc;
    mpc = ISR;
    push(3, 2, 0, 1, SAVE, last_saved, 0, "R11");
    ref_mem[SAVE] = 16'(last_saved);
  endfunction

  // reference model, compared every clock mid-cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      rec_t r;
      bit take;
      if (q.size() == 0) gen_instr();
      r = q.pop_front();
      chk("R12", "dbg_cycle", int'(dbg_cycle), r.cyc);
      chk("R12", "dbg_step", int'(dbg_step), r.step);
      chk(r.req, "mem_rd", int'(mem_rd), int'(r.rd));
      chk(r.req, "mem_wr", int'(mem_wr), int'(r.wr));
      if (r.rd || r.wr) chk(r.req, "mem_addr", int'(mem_addr), r.addr);
      if (r.wr) chk(r.req, "mem_wdata", int'(mem_wdata), r.wdata);
      chk(r.req, "pc_out", int'(pc_out), r.pc);
      chk(r.req, "acc_out", int'(acc_out), r.acc);
      if (mem_rd && mem_wr) chk("R3", "rd and wr together", 1, 0);
      if (dbg_cycle == 2'd3 && dbg_step == 2'd0) n_int_seen++;
      take = r.last && irq && (mie != 0);
      if (take) begin
        gen_int();
        n_int_exp++;
        mie = 0;
      end else if (int_arm) begin
        mie = 1;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = prog(a);
    cyc(1);
    for (int a = 0; a < DEPTH; a++) begin
      load_en = 1'b1; load_a = AW'(a); load_d = prog(a);
      cyc(1);
    end
    load_en = 1'b0;
    int_arm = 1'b1;             // ignored in reset
    cyc(2);
    int_arm = 1'b0;
    @(negedge clk);
    chk("R1", "reset dbg_cycle", int'(dbg_cycle), 0);
    chk("R1", "reset dbg_step", int'(dbg_step), 0);
    chk("R1", "reset pc", int'(pc_out), 0);
    chk("R1", "reset acc", int'(acc_out), 0);
    chk("R1", "reset mem_rd", int'(mem_rd), 0);
    chk("R1", "reset mem_wr", int'(mem_wr), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    cyc(150);
    irq = 1'b1; cyc(40);        // R10: enable clear, no entry
    irq = 1'b0;
    int_arm = 1'b1; cyc(1); int_arm = 1'b0;
    cyc(30);                    // R10: enabled but no request
    irq = 1'b1; cyc(100);       // exactly one entry
    irq = 1'b0; cyc(20);
    irq = 1'b1; int_arm = 1'b1; cyc(1); int_arm = 1'b0;
    cyc(100);
    irq = 1'b0; cyc(200);
    @(negedge clk);
    done = 1;
    chk("R10", "interrupt entries", n_int_seen, 2);
    chk("R10", "model entries", n_int_exp, 2);
    chk("R8", "return address at 0x50", int'(mem['h050]), 'h0006);
    chk("R4", "indirect save at 0x60", int'(mem['h060]), 'h0054);
    chk("R7", "counter at 0x43", int'(mem['h043]), 'h0002);
    chk("R11", "saved pc", int'(mem[SAVE]), last_saved);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule